// File: doc/BRIEF.md
# Fast-Lock Charge-Pump Current Timer

This block picks which of two programmed charge-pump current codes drives the pump. While a synthesizer moves to a new frequency, the pump current is raised so that the loop settles faster. It then drops back to the quieter steady-state current. Two configuration bits give three behaviours. With fast lock off, the gain bit selects the current directly. In the software-exit mode, writing the gain bit as 1 boosts the current until software writes it back to 0. In the timer-exit mode, the boost lasts a programmed number of phase-detector cycles. When the boost ends, the block emits a one-cycle pulse that tells the feedback-word register to clear its gain bit.

A current code c stands for a nominal current of 0.625 mA × (c + 1), which spans 0.625 mA to 5.0 mA. The block passes the selected code through unchanged. The timeout code TC gives 4·TC + 3 phase-detector cycles. Power-down and the three-state bit both float the pump output, and power-down also returns the timer to idle.

Top module: `fastlock_cp_timer`

## Requirements
- R1: After reset the block is idle: `cp_code` equals `cur1_code`, `gain_clr` is 0 and the timeout counter is 0.
- R2: With `fl_en` = 0 the gain bit level selects the code: `gain_bit` = 0 gives `cur1_code` and 1 gives `cur2_code`. The chosen code is passed unmodified for all eight values of each setting.
- R3: With `fl_en` = 1 and `fl_mode` = 0 (software exit), a write with `gain_bit` = 1 switches `cp_code` to `cur2_code` from the next cycle. It stays there, whatever the `pd_tick` activity, until a write with `gain_bit` = 0, which restores `cur1_code` from the next cycle.
- R4: With `fl_en` = 1 and `fl_mode` = 1 (timer exit), a write with `gain_bit` = 1 selects `cur2_code` for exactly 4·`tmo_code` + 3 `pd_tick` cycles. Cycles without `pd_tick` are not counted. `cur1_code` returns on the clock edge that takes in the last counted tick.
- R5: In timer-exit mode `gain_clr` is a single-cycle pulse. It is high in exactly the cycle in which `cp_code` first shows `cur1_code` again after the timeout.
- R6: A write with `gain_bit` = 1 during an active timeout reloads the counter and restarts the full period.
- R7: `pwr_dn` = 1 ends any boost, returns the counter to 0 without a `gain_clr` pulse, and forces `cp_hiz` high.
- R8: `tristate_bit` = 1 forces `cp_hiz` high without disturbing the selected code or the timer.
- R9: In timer-exit mode, a write with `gain_bit` = 0 during a timeout ends the boost on the next cycle with no `gain_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur1_code | input | CODE_W | Steady-state current code (setting 1) |
| cur2_code | input | CODE_W | Boost current code (setting 2) |
| fl_en | input | 1 | Fast lock enable |
| fl_mode | input | 1 | 0 = software exit, 1 = timer exit |
| tmo_code | input | TC_W | Timeout code, period 4·code + 3 ticks |
| gain_bit | input | 1 | Gain bit of the feedback-word register |
| word_wr | input | 1 | One-cycle strobe for each feedback-word write |
| pd_tick | input | 1 | One phase-detector cycle has elapsed |
| tristate_bit | input | 1 | Force the pump output to high impedance |
| pwr_dn | input | 1 | Power-down |
| cp_code | output | CODE_W | Active current code |
| cp_hiz | output | 1 | Charge pump output in three-state |
| gain_clr | output | 1 | Pulse that clears the stored gain bit |

## Verification
The bench uses the default parameters: 3-bit current codes and a 4-bit timeout code. At this size every code pair can be swept in the direct-select mode. Every one of the sixteen timeout codes is also run to expiry, with ticks on only every other cycle, so both the period length and the tick gating are checked for the full range up to 63 ticks. Reload, early software exit, power-down and three-state are checked mid-timeout at one short period.

// File: rtl/fastlock_cp_timer.sv
module fastlock_cp_timer #(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] cur1_code,
  input  logic [CODE_W-1:0] cur2_code,
  input  logic              fl_en,
  input  logic              fl_mode,
  input  logic [TC_W-1:0]   tmo_code,
  input  logic              gain_bit,
  input  logic              word_wr,
  input  logic              pd_tick,
  input  logic              tristate_bit,
  input  logic              pwr_dn,
  output logic [CODE_W-1:0] cp_code,
  output logic              cp_hiz,
  output logic              gain_clr
);
  localparam int CNT_W = TC_W + 2;

  logic             boost;
  logic [CNT_W-1:0] cnt;

  wire timed  = fl_en & fl_mode;
  wire run    = timed & boost & pd_tick & ~word_wr;
  wire last   = cnt <= CNT_W'(1);
  wire expire = run & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boost    <= 1'b0;
      cnt      <= '0;
      gain_clr <= 1'b0;
    end else if (pwr_dn || !fl_en) begin
      boost    <= 1'b0;
      cnt      <= '0;
      gain_clr <= 1'b0;
    end else begin
      gain_clr <= expire;
      if (word_wr) begin
        boost <= gain_bit;
        cnt   <= (timed && gain_bit) ? {tmo_code, 2'b11} : '0;
      end else if (run) begin
        if (last) begin
          boost <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end

  wire sel2 = fl_en ? boost : gain_bit;

  assign cp_code = sel2 ? cur2_code : cur1_code;
  assign cp_hiz  = tristate_bit | pwr_dn;
endmodule

module fastlock_cp_timer_chk #(
  parameter int CODE_W = 3,
  parameter int TC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fl_en,
  input logic              fl_mode,
  input logic [TC_W-1:0]   tmo_code,
  input logic              gain_bit,
  input logic              word_wr,
  input logic              pd_tick,
  input logic              pwr_dn,
  input logic              gain_clr,
  input logic              boost,
  input logic [TC_W+1:0]   cnt
);
  p_clr_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gain_clr |=> !gain_clr);

  p_pd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_dn |=> (cnt == '0 && !boost && !gain_clr));

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_wr && gain_bit && fl_en && fl_mode && !pwr_dn) |=> (cnt == {$past(tmo_code), 2'b11}));

  p_tick_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (boost && fl_en && fl_mode && pd_tick && !word_wr && !pwr_dn && cnt > 1) |=> (cnt == $past(cnt) - 1'b1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_tick && !word_wr && !pwr_dn && fl_en) |=> $stable(cnt));
endmodule

bind fastlock_cp_timer fastlock_cp_timer_chk #(.CODE_W(CODE_W), .TC_W(TC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .fl_en(fl_en), .fl_mode(fl_mode), .tmo_code(tmo_code),
  .gain_bit(gain_bit), .word_wr(word_wr), .pd_tick(pd_tick), .pwr_dn(pwr_dn),
  .gain_clr(gain_clr), .boost(boost), .cnt(cnt)
);

// File: tb/test_fastlock_cp_timer.sv
module test_fastlock_cp_timer;
  logic clk = 0, rst_n = 0;
  logic [2:0] cur1_code = 3'd2, cur2_code = 3'd6;
  logic fl_en = 0, fl_mode = 0, gain_bit = 0, word_wr = 0, pd_tick = 0;
  logic tristate_bit = 0, pwr_dn = 0;
  logic [3:0] tmo_code = 0;
  logic [2:0] cp_code;
  logic cp_hiz, gain_clr;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fastlock_cp_timer i_fastlock_cp_timer (
    .clk(clk), .rst_n(rst_n), .cur1_code(cur1_code), .cur2_code(cur2_code),
    .fl_en(fl_en), .fl_mode(fl_mode), .tmo_code(tmo_code), .gain_bit(gain_bit),
    .word_wr(word_wr), .pd_tick(pd_tick), .tristate_bit(tristate_bit), .pwr_dn(pwr_dn),
    .cp_code(cp_code), .cp_hiz(cp_hiz), .gain_clr(gain_clr));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit wr, bit g, bit tick);
    word_wr = wr; gain_bit = g; pd_tick = tick;
    @(posedge clk); #1;
    word_wr = 0; pd_tick = 0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R1 code", cp_code, 2); chk("R1 clr", gain_clr, 0); chk("R1 hiz", cp_hiz, 0);
    rst_n = 1;
    cyc(0, 0, 1);
    chk("R1 idle code", cp_code, 2);

    // R2: direct select over all code pairs
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int g = 0; g < 2; g++) begin
          cur1_code = 3'(a); cur2_code = 3'(b); gain_bit = g[0];
          #1 chk("R2", cp_code, g ? b : a);
        end
    cur1_code = 3'd1; cur2_code = 3'd5; gain_bit = 0;

    // R3: software exit
    fl_en = 1; fl_mode = 0;
    cyc(0, 0, 0);
    cyc(1, 1, 0); chk("R3 boost", cp_code, 5);
    for (int k = 0; k < 80; k++) begin
      cyc(0, 1, 1);
      chk("R3 hold", cp_code, 5); chk("R3 no clr", gain_clr, 0);
    end
    cyc(1, 0, 0); chk("R3 exit", cp_code, 1);

    // R4/R5: every timeout code, ticks on alternate cycles
    fl_mode = 1;
    for (int tc = 0; tc < 16; tc++) begin
      int t;
      t = 4 * tc + 3;
      tmo_code = 4'(tc);
      cyc(1, 1, 0);
      chk("R4 start", cp_code, 5);
      for (int k = 1; k <= t; k++) begin
        cyc(0, 1, 0);
        chk("R4 gap", cp_code, 5);
        cyc(0, 1, 1);
        chk("R4 period", cp_code, (k == t) ? 1 : 5);
        chk("R5 pulse", gain_clr, (k == t) ? 1 : 0);
      end
      cyc(0, 0, 1);
      chk("R5 single", gain_clr, 0); chk("R4 stay", cp_code, 1);
    end

    // R6 and R8: reload during timeout, with three-state set
    tmo_code = 4'd1;
    cyc(1, 1, 0);
    repeat (4) cyc(0, 1, 1);
    tristate_bit = 1;
    #1 chk("R8 hiz", cp_hiz, 1);
    cyc(1, 1, 0);
    for (int k = 1; k <= 7; k++) begin
      cyc(0, 1, 1);
      chk("R6 restart", cp_code, (k == 7) ? 1 : 5);
      chk("R6 clr", gain_clr, (k == 7) ? 1 : 0);
      chk("R8 hiz hold", cp_hiz, 1);
    end
    tristate_bit = 0;
    #1 chk("R8 release", cp_hiz, 0);

    // R9: software write of 0 ends timed boost
    cyc(1, 1, 0);
    repeat (2) cyc(0, 1, 1);
    cyc(1, 0, 0);
    chk("R9 exit", cp_code, 1); chk("R9 no clr", gain_clr, 0);
    for (int k = 0; k < 70; k++) begin
      cyc(0, 0, 1);
      chk("R9 quiet", gain_clr, 0);
    end

    // R7: power-down mid timeout
    cyc(1, 1, 0);
    repeat (2) cyc(0, 1, 1);
    pwr_dn = 1;
    #1 chk("R7 hiz", cp_hiz, 1);
    cyc(0, 1, 1);
    pwr_dn = 0;
    #1 chk("R7 code", cp_code, 1); chk("R7 clr", gain_clr, 0); chk("R7 hiz off", cp_hiz, 0);
    for (int k = 0; k < 70; k++) begin
      cyc(0, 1, 1);
      chk("R7 idle", gain_clr, 0);
      chk("R7 idle code", cp_code, 1);
    end

    done = 1;
    finish_run();
  end
endmodule